// File: doc/BRIEF.md
# Target-Switch Ordering Fence

This block sits between a processor's request port and the network request channel of a multi-target interconnect. Each request address is decoded through a fixed, parameterised address map into a target index. Requests that go to the same target are passed straight through, so several of them can be in flight at once. A request for a different target is held until every request already issued has been acknowledged. The network returns one acknowledge for each request, writes included.

The purpose is ordering between targets. Lock words live on their own semaphore target. When software releases a lock after updating shared data on a data target, the release crosses a target boundary. It therefore cannot leave before all of the data writes have been acknowledged, so it cannot overtake the data it protects. The same rule covers the move in the other direction, from lock target back to data target.

Both request sides use valid/ready. A request is transferred in a cycle where `cpu_valid` and `cpu_ready` are both high. `net_valid` and `cpu_ready` are driven combinationally from the inputs and the current fence state. The network can apply back-pressure through `net_ready`. The fence can hold a request by keeping both `net_valid` and `cpu_ready` low. A held request must stay offered, unchanged, on the processor side. The acknowledge input is a plain one-cycle pulse, and at most one acknowledge arrives per cycle.

Top module: `fnc_ordering_fence`

## Requirements
- R1: After reset the outstanding count is zero, so the first request offered to any target is accepted. A reset applied while requests are outstanding clears that state.
- R2: `net_valid` is high only when `cpu_valid` is high and the fence is open. `cpu_ready` equals `net_ready` ANDed with the fence being open. Address, write flag and write data pass through unchanged in the same cycle. A request that is offered but not handshaked is not counted.
- R3: The target index is set by the lowest-numbered map entry i for which (address AND mask[i]) equals base[i]. An address that matches no entry goes to target index NUM_MAP. With the default map: entry 0 is base 0x1F000000 / mask 0xFF000000 (semaphore target), entry 1 is base 0x10000000 / mask 0xF0000000, entry 2 is base 0x00000000 / mask 0xF0000000, and the default is target 3.
- R4: While requests are outstanding to the current target, further requests to that target are accepted back to back, up to MAX_OUT outstanding.
- R5: While the outstanding count is non-zero, a request whose decoded target differs from the current target sees `cpu_ready` and `net_valid` low. It is accepted from the cycle after the clock edge at which the last outstanding acknowledge is taken.
- R6: When MAX_OUT requests are outstanding, every request, including one to the current target, is held. It is released in the cycle after one acknowledge is taken.
- R7: In a cycle with both a handshake and an acknowledge, the outstanding count is unchanged.
- R8: Write requests count as outstanding exactly as reads do, and they hold a target switch until they are acknowledged.
- R9: An acknowledge that arrives while nothing is outstanding is ignored and does not underflow the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request valid |
| cpu_ready | output | 1 | Request accepted this cycle |
| cpu_addr | input | AW | Request address |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_wdata | input | DW | Write data |
| net_valid | output | 1 | Network request valid |
| net_ready | input | 1 | Network can take a request |
| net_addr | output | AW | Address towards the network |
| net_we | output | 1 | Write flag towards the network |
| net_wdata | output | DW | Write data towards the network |
| net_tgt | output | TW | Decoded target index of `cpu_addr` |
| ack_valid | input | 1 | One acknowledge from the network (read data or write completion) |

## Verification
`net_valid`, `cpu_ready` and the passed-through fields respond to the inputs in the same cycle. The bench drives each input set just after a falling edge and samples those outputs 1 ns later, before the next rising edge. A handshake or acknowledge changes the outstanding count at the next rising edge. Its effect on stalling is therefore checked in the following cycle's sample. For example, a held switch request is expected open in the sample right after the edge that took the last acknowledge, and the saturation tests step the count one edge at a time to see exactly when a hold starts and ends.

// File: rtl/fnc_pkg.sv
package fnc_pkg;
  // Fence decision for the request currently offered
  typedef enum logic [1:0] {
    FNC_IDLE   = 2'd0,  // nothing outstanding: any target may go
    FNC_SAME   = 2'd1,  // outstanding, same target: pipeline
    FNC_SWITCH = 2'd2,  // outstanding, other target: hold
    FNC_FULL   = 2'd3   // count saturated: hold
  } fnc_gate_e;
endpackage

// File: rtl/fnc_addr_map.sv
module fnc_addr_map #(
  parameter int AW      = 32,
  parameter int NUM_MAP = 3,
  parameter int TW      = $clog2(NUM_MAP + 1),
  parameter logic [NUM_MAP*AW-1:0] BASES = '0,
  parameter logic [NUM_MAP*AW-1:0] MASKS = '0
) (
  input  logic [AW-1:0] addr,
  output logic [TW-1:0] tgt
);
  logic [NUM_MAP-1:0] hit;

  generate
    for (genvar g = 0; g < NUM_MAP; g++) begin : g_ent
      assign hit[g] = ((addr & MASKS[g*AW +: AW]) == BASES[g*AW +: AW]);
    end
  endgenerate

  // lowest index wins: scan downward so the last write is the lowest hit
  always_comb begin
    tgt = TW'(NUM_MAP);
    for (int i = NUM_MAP - 1; i >= 0; i--) begin
      if (hit[i]) tgt = TW'(i);
    end
  end
endmodule

// File: rtl/fnc_out_counter.sv
module fnc_out_counter #(
  parameter int MAX_OUT = 4,
  parameter int CW      = $clog2(MAX_OUT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] cnt,
  output logic          zero,
  output logic          full
);
  logic dec_ok;

  assign dec_ok = dec && (cnt != '0);   // stray acknowledge is dropped
  assign zero   = (cnt == '0);
  assign full   = (cnt == CW'(MAX_OUT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else begin
      case ({inc, dec_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/fnc_switch_gate.sv
module fnc_switch_gate
  import fnc_pkg::*;
#(
  parameter int TW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] req_tgt,
  input  logic          issue,
  input  logic          zero,
  input  logic          full,
  output logic          open,
  output logic [TW-1:0] cur_tgt
);
  fnc_gate_e state;

  always_comb begin
    if (full)                    state = FNC_FULL;
    else if (zero)               state = FNC_IDLE;
    else if (req_tgt == cur_tgt) state = FNC_SAME;
    else                         state = FNC_SWITCH;
  end

  assign open = (state == FNC_IDLE) || (state == FNC_SAME);

  // the current target only moves when the pipe is empty
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_tgt <= '0;
    end else if (issue && zero) begin
      cur_tgt <= req_tgt;
    end
  end
endmodule

// File: rtl/fnc_ordering_fence.sv
module fnc_ordering_fence #(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int NUM_MAP = 3,
  parameter int MAX_OUT = 4,
  parameter logic [NUM_MAP*AW-1:0] BASES =
    {32'h0000_0000, 32'h1000_0000, 32'h1F00_0000},
  parameter logic [NUM_MAP*AW-1:0] MASKS =
    {32'hF000_0000, 32'hF000_0000, 32'hFF00_0000},
  localparam int TW = $clog2(NUM_MAP + 1),
  localparam int CW = $clog2(MAX_OUT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_valid,
  output logic          cpu_ready,
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_we,
  input  logic [DW-1:0] cpu_wdata,
  output logic          net_valid,
  input  logic          net_ready,
  output logic [AW-1:0] net_addr,
  output logic          net_we,
  output logic [DW-1:0] net_wdata,
  output logic [TW-1:0] net_tgt,
  input  logic          ack_valid
);
  logic          open;
  logic          fire;
  logic          cnt_zero;
  logic          cnt_full;
  logic [CW-1:0] out_cnt;
  logic [TW-1:0] cur_tgt;

  fnc_addr_map #(
    .AW(AW), .NUM_MAP(NUM_MAP), .TW(TW), .BASES(BASES), .MASKS(MASKS)
  ) u_map (
    .addr (cpu_addr),
    .tgt  (net_tgt)
  );

  fnc_switch_gate #(.TW(TW)) u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_tgt (net_tgt),
    .issue   (fire),
    .zero    (cnt_zero),
    .full    (cnt_full),
    .open    (open),
    .cur_tgt (cur_tgt)
  );

  fnc_out_counter #(.MAX_OUT(MAX_OUT), .CW(CW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (fire),
    .dec   (ack_valid),
    .cnt   (out_cnt),
    .zero  (cnt_zero),
    .full  (cnt_full)
  );

  assign net_valid = cpu_valid && open;
  assign cpu_ready = net_ready && open;
  assign fire      = cpu_valid && cpu_ready;
  assign net_addr  = cpu_addr;
  assign net_we    = cpu_we;
  assign net_wdata = cpu_wdata;
endmodule

// File: rtl/fnc_ordering_fence_chk.sv
module fnc_ordering_fence_chk #(
  parameter int CW      = 3,
  parameter int TW      = 2,
  parameter int MAX_OUT = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_valid,
  input logic          cpu_ready,
  input logic          net_valid,
  input logic          net_ready,
  input logic [TW-1:0] net_tgt,
  input logic          ack_valid,
  input logic [CW-1:0] out_cnt,
  input logic [TW-1:0] cur_tgt
);
  logic fire;
  assign fire = cpu_valid && cpu_ready;

  p_valid_needs_cpu_r2: assert property (@(posedge clk) disable iff (!rst_n)
    net_valid |-> cpu_valid);

  p_ready_needs_net_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> net_ready);

  p_switch_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_cnt != '0 && cpu_valid && net_tgt != cur_tgt) |-> (!net_valid && !cpu_ready));

  p_target_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_cnt != '0) |=> (cur_tgt == $past(cur_tgt)));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_cnt <= CW'(MAX_OUT));

  p_full_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_cnt == CW'(MAX_OUT)) |-> !net_valid);

  p_both_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && ack_valid && out_cnt != '0) |=> $stable(out_cnt));

  p_issue_adds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !ack_valid) |=> (out_cnt == CW'($past(out_cnt) + 1'b1)));

  p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_cnt == '0 && !fire) |=> (out_cnt == '0));
endmodule

bind fnc_ordering_fence fnc_ordering_fence_chk #(
  .CW(CW), .TW(TW), .MAX_OUT(MAX_OUT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_valid (cpu_valid),
  .cpu_ready (cpu_ready),
  .net_valid (net_valid),
  .net_ready (net_ready),
  .net_tgt   (net_tgt),
  .ack_valid (ack_valid),
  .out_cnt   (out_cnt),
  .cur_tgt   (cur_tgt)
);

// File: tb/fnc_ordering_fence_tb.sv
`timescale 1ns/1ps
module fnc_ordering_fence_tb;
  localparam logic [31:0] A_SEM = 32'h1F00_0010;  // target 0
  localparam logic [31:0] A_D1  = 32'h1000_0020;  // target 1
  localparam logic [31:0] A_D2  = 32'h0000_0040;  // target 2
  localparam logic [31:0] A_DEF = 32'h8000_0000;  // target 3 (no match)
  localparam logic [31:0] A_1E  = 32'h1E00_0000;  // target 1 (entry 0 misses)

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_valid = 1'b0, cpu_we = 1'b0, net_ready = 1'b0, ack_valid = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic        cpu_ready, net_valid, net_we;
  logic [31:0] net_addr, net_wdata;
  logic [1:0]  net_tgt;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  fnc_ordering_fence u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_addr(cpu_addr),
    .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
    .net_valid(net_valid), .net_ready(net_ready), .net_addr(net_addr),
    .net_we(net_we), .net_wdata(net_wdata), .net_tgt(net_tgt),
    .ack_valid(ack_valid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // apply one cycle of inputs after a falling edge and let them settle
  task automatic drive(input logic v, input logic [31:0] a, input logic w,
                       input logic r, input logic k);
    @(negedge clk);
    cpu_valid = v; cpu_addr = a; cpu_we = w; cpu_wdata = a ^ 32'h5A5A;
    net_ready = r; ack_valid = k;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    cpu_valid = 0; ack_valid = 0; net_ready = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    drive(0, A_D1, 0, 1, 0);
    chk("R1 idle net_valid", net_valid, 0);
    drive(1, A_SEM, 0, 1, 0);
    chk("R1 first request accepted", cpu_ready, 1);
    drive(1, A_D1, 0, 1, 0);                  // count 1 on target 0
    chk("R1 switch held before reset", cpu_ready, 0);
    do_reset();
    drive(1, A_D1, 0, 1, 0);
    chk("R1 reset clears outstanding", cpu_ready, 1);
    drive(0, A_D1, 0, 1, 1);                  // drain
  endtask

  task automatic t_decode();
    drive(0, A_SEM, 0, 1, 0); chk("R3 semaphore entry", net_tgt, 0);
    drive(0, A_D1,  0, 1, 0); chk("R3 entry 1", net_tgt, 1);
    drive(0, A_1E,  0, 1, 0); chk("R3 priority fallthrough", net_tgt, 1);
    drive(0, A_D2,  0, 1, 0); chk("R3 entry 2", net_tgt, 2);
    drive(0, A_DEF, 0, 1, 0); chk("R3 default target", net_tgt, 3);
  endtask

  task automatic t_backpressure();
    drive(1, A_DEF, 1, 0, 0);
    chk("R2 valid under back-pressure", net_valid, 1);
    chk("R2 ready follows net_ready", cpu_ready, 0);
    chk("R2 addr pass", net_addr, A_DEF);
    chk("R2 we pass", net_we, 1);
    chk("R2 wdata pass", net_wdata, A_DEF ^ 32'h5A5A);
    drive(1, A_D2, 0, 1, 0);
    chk("R2 no count without handshake", cpu_ready, 1);
    drive(0, A_D2, 0, 1, 1);
  endtask

  task automatic t_fence();
    drive(1, A_D1, 0, 1, 0); chk("R4 pipe 1", cpu_ready, 1);
    drive(1, A_D1, 1, 1, 0); chk("R4 pipe 2 write", cpu_ready, 1);
    drive(1, A_D1, 1, 1, 0); chk("R4 pipe 3 write", cpu_ready, 1);
    drive(1, A_SEM, 0, 1, 0);
    chk("R5 switch ready low", cpu_ready, 0);
    chk("R5 switch valid low", net_valid, 0);
    for (int i = 0; i < 3; i++) begin
      drive(1, A_SEM, 0, 1, 1);
      chk("R5 held while acks pending", net_valid, 0);
    end
    drive(1, A_SEM, 0, 1, 0);
    chk("R5 open after last ack", cpu_ready, 1);
    chk("R5 semaphore target", net_tgt, 0);
    drive(0, A_SEM, 0, 1, 1);
  endtask

  task automatic t_write_drain();
    drive(1, A_D2, 1, 1, 0); chk("R8 write issued", cpu_ready, 1);
    drive(1, A_D1, 0, 1, 0); chk("R8 write holds switch", cpu_ready, 0);
    drive(1, A_D1, 0, 1, 1); chk("R8 held until write ack", cpu_ready, 0);
    drive(1, A_D1, 0, 1, 0); chk("R8 open after write ack", cpu_ready, 1);
    drive(0, A_D1, 0, 1, 1);
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 4; i++) begin
      drive(1, A_D2, 0, 1, 0); chk("R4 fill to max", cpu_ready, 1);
    end
    drive(1, A_D2, 0, 1, 0);
    chk("R6 full ready low", cpu_ready, 0);
    chk("R6 full valid low", net_valid, 0);
    drive(1, A_D2, 0, 1, 1); chk("R6 still held during ack", cpu_ready, 0);
    drive(1, A_D2, 0, 1, 1); chk("R6 released after ack", cpu_ready, 1);
    drive(1, A_D2, 0, 1, 0); chk("R7 issue+ack kept count 3", cpu_ready, 1);
    drive(1, A_D2, 0, 1, 0); chk("R7 count back at max", cpu_ready, 0);
    for (int i = 0; i < 4; i++) drive(0, A_D2, 0, 1, 1);
    drive(1, A_D1, 0, 1, 0); chk("R7 fully drained", cpu_ready, 1);
    drive(0, A_D1, 0, 1, 1);
  endtask

  task automatic t_stray();
    drive(0, A_D1, 0, 1, 1);                  // ack with nothing outstanding
    drive(1, A_D1, 0, 1, 0); chk("R9 accept after stray ack", cpu_ready, 1);
    drive(1, A_D2, 0, 1, 0); chk("R9 count is one, not wrapped", cpu_ready, 0);
    drive(1, A_D2, 0, 1, 1); chk("R9 held until ack", cpu_ready, 0);
    drive(1, A_D2, 0, 0, 0);
    chk("R9 open, back-pressured valid", net_valid, 1);
    chk("R9 open, back-pressured ready", cpu_ready, 0);
    drive(0, A_D2, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_decode();
    t_backpressure();
    t_fence();
    t_write_drain();
    t_saturate();
    t_stray();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule